// File: doc/BRIEF.md
# Buffered UART Transmitter with Half-Duplex Direction Control

This block is the transmit side of an asynchronous serial port. Host writes land in a small byte queue. A shift engine pulls them one at a time and sends each as a ten-bit frame on a line that rests high: one low start bit, eight data bits with the least significant first, and one high stop bit. Each bit lasts a fixed number of baud ticks, and the ticks come from an external rate generator.

A halt input freezes the queue at its output. While halt is high no new frame begins, and writes keep filling the queue. If halt rises during a frame, that frame still runs through its stop bit. When halt falls, the queued bytes go out in the order they were written.

An automatic direction mode drives an active-low output for the enable of a half-duplex line driver. In this mode the output rises as soon as a byte is accepted, before that byte's start bit. It falls only after the stop bit of the last queued character has ended. The same mode moves the transmit interrupt from "queue empty" to "queue empty and shift engine idle".

Top module: `uart_tx_dir`

## Requirements
- R1: After reset, txd is 1, tx_irq is 1, dir_n is 1, tx_ovf is 0, and the halt and direction modes are set only by their inputs.
- R2: A frame is a start bit of 0, then eight data bits from bit 0 to bit 7, then a stop bit of 1. Each bit lasts TICKS_PER_BIT baud ticks (16 by default), and txd is 1 when no frame is in progress.
- R3: Accepted bytes are sent in the order they were written. The queue holds up to DEPTH bytes (16 by default).
- R4: A write while the queue holds DEPTH bytes is dropped and never sent. It sets tx_ovf, which stays 1 until reset.
- R5: While tx_halt is 1 and no frame is in progress, no start bit is sent, and written bytes accumulate in the queue.
- R6: If tx_halt rises during a frame, that frame completes through its stop bit and the next queued byte does not start.
- R7: When tx_halt returns to 0, all queued bytes are sent in write order.
- R8: With dir_auto_en at 0, tx_irq is 1 exactly when the queue is empty, including while the last byte is still being shifted out.
- R9: With dir_auto_en at 1, tx_irq is 1 only when the queue is empty and no frame is in progress.
- R10: With dir_auto_en at 1, dir_n is 1 in the clock cycle after a write is accepted. This comes at least one cycle before that byte's start bit appears on txd.
- R11: With dir_auto_en at 1, dir_n stays 1 through every frame. It falls to 0 only when the stop bit of the last queued byte ends, which is 10*TICKS_PER_BIT baud ticks after that byte's start bit began. With dir_auto_en at 0, dir_n is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Byte write strobe, one cycle per byte |
| wr_data | input | DATA_W | Byte to queue |
| baud_tick | input | 1 | One-cycle pulse from the rate generator |
| tx_halt | input | 1 | 1 = do not start new frames |
| dir_auto_en | input | 1 | 1 = automatic direction control and shift-empty interrupt |
| txd | output | 1 | Serial line, idles high |
| dir_n | output | 1 | Driver direction, high while the line is being driven |
| tx_irq | output | 1 | Transmit-empty interrupt level |
| tx_ovf | output | 1 | Sticky flag for dropped writes |

## Verification
The bench builds the block with DEPTH=4 and TICKS_PER_BIT=4. The short queue lets the overflow and drop behaviour be reached after a handful of writes. The four-tick bit keeps frames at forty ticks, so the exact timing of the direction fall can be measured in cycles. A run with baud ticks spaced three cycles apart shows that bit length follows ticks rather than clocks. Halt is toggled both between frames and in the middle of a frame.

// File: rtl/uart_tx_dir_pkg.sv
`timescale 1ns/1ps
package uart_tx_dir_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_START = 2'd1,
      PH_DATA  = 2'd2,
      PH_STOP  = 2'd3
   } tx_phase_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/tx_byte_fifo.sv
`timescale 1ns/1ps
module tx_byte_fifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty,
   output logic              full,
   output logic              ovf
);
   import uart_tx_dir_pkg::*;

   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
   logic [CW-1:0]     count;
   logic              wr_ok;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign wr_ok   = wr_en && !full;
   assign rd_data = mem[rd_ptr];

   generate
      if (is_pow2(DEPTH)) begin : g_wrap_nat
         assign wr_ptr_nx = wr_ptr + 1'b1;
         assign rd_ptr_nx = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_ptr_nx = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_ptr_nx = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovf    <= 1'b0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr_nx;
         if (rd_en) rd_ptr <= rd_ptr_nx;
         unique case ({wr_ok, rd_en})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (wr_en && full) ovf <= 1'b1;
      end
   end

   // R4: a write into a full queue raises the overflow flag
   a_r4_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full) |=> ovf);
   // R4: overflow flag is sticky
   a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   // R3: the shift engine never pops an empty queue
   a_r3_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !empty);
   // R3: occupancy never exceeds the depth
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

endmodule

// File: rtl/tx_shift_eng.sv
`timescale 1ns/1ps
module tx_shift_eng #(
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned TICKS_PER_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              halt,
   input  logic              avail,
   input  logic [DATA_W-1:0] ld_data,
   output logic              pop,
   output logic              busy,
   output logic              txd
);
   import uart_tx_dir_pkg::*;

   localparam int unsigned TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
   localparam int unsigned BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   tx_phase_e         phase;
   logic [TW-1:0]     tick_cnt;
   logic [BW-1:0]     bit_cnt;
   logic [DATA_W-1:0] shreg;
   logic              bit_end;

   assign bit_end = baud_tick && (tick_cnt == TW'(TICKS_PER_BIT - 1));
   assign pop     = (phase == PH_IDLE) && avail && !halt;
   assign busy    = (phase != PH_IDLE);

   always_comb begin
      unique case (phase)
         PH_START: txd = 1'b0;
         PH_DATA:  txd = shreg[0];
         default:  txd = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         tick_cnt <= '0;
         bit_cnt  <= '0;
         shreg    <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               tick_cnt <= '0;
               if (pop) begin
                  phase <= PH_START;
                  shreg <= ld_data;
               end
            end
            PH_START: begin
               if (bit_end) begin
                  phase    <= PH_DATA;
                  bit_cnt  <= '0;
                  tick_cnt <= '0;
               end else if (baud_tick) begin
                  tick_cnt <= tick_cnt + 1'b1;
               end
            end
            PH_DATA: begin
               if (bit_end) begin
                  tick_cnt <= '0;
                  shreg    <= shreg >> 1;
                  if (bit_cnt == BW'(DATA_W - 1)) phase <= PH_STOP;
                  else                            bit_cnt <= bit_cnt + 1'b1;
               end else if (baud_tick) begin
                  tick_cnt <= tick_cnt + 1'b1;
               end
            end
            default: begin
               if (bit_end) begin
                  phase    <= PH_IDLE;
                  tick_cnt <= '0;
               end else if (baud_tick) begin
                  tick_cnt <= tick_cnt + 1'b1;
               end
            end
         endcase
      end
   end

   // R5: an idle engine stays idle while halted
   a_r5_halt_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && halt) |=> !busy);
   // R2: a frame opens with a low start bit
   a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !txd);
   // R6: a frame only ends out of the stop bit, with the line high
   a_r6_end_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(phase) == PH_STOP) && $past(txd));
   // R2: the bit position only moves on a baud tick
   a_r2_tick_paced: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !baud_tick) |=> $stable(bit_cnt));

endmodule

// File: rtl/tx_dir_ctrl.sv
`timescale 1ns/1ps
module tx_dir_ctrl (
   input  logic auto_en,
   input  logic q_empty,
   input  logic busy,
   output logic dir_n,
   output logic tx_irq
);
   logic line_active;

   assign line_active = !q_empty || busy;

   always_comb begin
      if (auto_en) begin
         dir_n  = line_active;
         tx_irq = !line_active;
      end else begin
         dir_n  = 1'b1;
         tx_irq = q_empty;
      end
   end
endmodule

// File: rtl/uart_tx_dir.sv
`timescale 1ns/1ps
module uart_tx_dir #(
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned DEPTH         = 16,
   parameter int unsigned TICKS_PER_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              baud_tick,
   input  logic              tx_halt,
   input  logic              dir_auto_en,
   output logic              txd,
   output logic              dir_n,
   output logic              tx_irq,
   output logic              tx_ovf
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("uart_tx_dir: DEPTH must be at least 2");
      end
      if (TICKS_PER_BIT < 2) begin : g_bad_ticks
         $error("uart_tx_dir: TICKS_PER_BIT must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("uart_tx_dir: DATA_W must be at least 2");
      end
   endgenerate

   logic              q_empty, q_full, q_pop, eng_busy;
   logic [DATA_W-1:0] q_data;

   tx_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (q_pop),
      .rd_data (q_data),
      .empty   (q_empty),
      .full    (q_full),
      .ovf     (tx_ovf)
   );

   tx_shift_eng #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .halt      (tx_halt),
      .avail     (!q_empty),
      .ld_data   (q_data),
      .pop       (q_pop),
      .busy      (eng_busy),
      .txd       (txd)
   );

   tx_dir_ctrl u_dir (
      .auto_en (dir_auto_en),
      .q_empty (q_empty),
      .busy    (eng_busy),
      .dir_n   (dir_n),
      .tx_irq  (tx_irq)
   );

   // R10: an accepted write turns the driver on by the next cycle
   a_r10_dir_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !q_full) |=> dir_n);
   // R11: the driver is off only while the line rests high
   a_r11_dir_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_auto_en && !dir_n) |-> (txd && !eng_busy));
   // R9: in automatic mode the interrupt waits for the shift engine
   a_r9_irq_shift_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_auto_en && tx_irq) |-> !eng_busy);
   // R8: in standard mode a pending byte keeps the interrupt low
   a_r8_irq_holding: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_auto_en && q_pop) |-> !tx_irq);

endmodule

// File: tb/uart_tx_dir_bench.sv
`timescale 1ns/1ps
module uart_tx_dir_bench;
   localparam int DEPTH = 4;
   localparam int TPB   = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       baud_tick = 1'b0;
   logic       tx_halt = 1'b0;
   logic       dir_auto_en = 1'b0;
   logic       txd, dir_n, tx_irq, tx_ovf;

   int checks = 0;
   int errors = 0;
   int frames = 0;
   int tick_div = 1;
   int tick_cnt = 0;
   logic [7:0] exp_q[$];

   uart_tx_dir #(.DATA_W(8), .DEPTH(DEPTH), .TICKS_PER_BIT(TPB)) u_uart_tx_dir (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .baud_tick(baud_tick), .tx_halt(tx_halt), .dir_auto_en(dir_auto_en),
      .txd(txd), .dir_n(dir_n), .tx_irq(tx_irq), .tx_ovf(tx_ovf)
   );

   always #4 clk = ~clk;

   always @(negedge clk) begin
      tick_cnt  = (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
      baud_tick = (tick_cnt == 0);
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic put_byte(input logic [7:0] d, input bit kept);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      if (kept) exp_q.push_back(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_frames(input int n);
      while (frames < n) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // monitor: decode frames at mid-bit and compare with the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && txd == 1'b0) begin
            int bitc;
            logic [7:0] got;
            logic [7:0] exp;
            bitc = TPB * tick_div;
            repeat (bitc / 2) @(negedge clk);
            check(txd == 1'b0, "R2 start bit", int'(txd), 0);
            for (int i = 0; i < 8; i++) begin
               repeat (bitc) @(negedge clk);
               got[i] = txd;
               if (dir_auto_en) check(dir_n == 1'b1, "R11 dir high during frame", int'(dir_n), 1);
            end
            repeat (bitc) @(negedge clk);
            check(txd == 1'b1, "R2 stop bit", int'(txd), 1);
            if (dir_auto_en) check(dir_n == 1'b1, "R11 dir high in stop bit", int'(dir_n), 1);
            if (exp_q.size() == 0) begin
               check(1'b0, "R3 unexpected frame", int'(got), -1);
            end else begin
               exp = exp_q.pop_front();
               check(got == exp, "R3 R2 frame data", int'(got), int'(exp));
            end
            frames++;
         end
      end
   end

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n;
      int lows;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(txd == 1'b1,    "R1 txd", int'(txd), 1);
      check(tx_irq == 1'b1, "R1 tx_irq", int'(tx_irq), 1);
      check(dir_n == 1'b1,  "R1 dir_n", int'(dir_n), 1);
      check(tx_ovf == 1'b0, "R1 tx_ovf", int'(tx_ovf), 0);

      // R8 standard mode: interrupt follows the queue, not the shifter
      put_byte(8'hA5, 1'b1);
      check(tx_irq == 1'b0, "R8 irq low while queued", int'(tx_irq), 0);
      repeat (3) @(negedge clk);
      check(tx_irq == 1'b1, "R8 irq high while shifting", int'(tx_irq), 1);
      check(dir_n == 1'b1,  "R11 dir held high in standard mode", int'(dir_n), 1);
      wait_frames(1);

      // R3 several patterns back to back
      put_byte(8'h00, 1'b1);
      put_byte(8'hFF, 1'b1);
      put_byte(8'h81, 1'b1);
      wait_frames(4);

      // automatic direction mode
      @(negedge clk);
      dir_auto_en = 1'b1;
      @(negedge clk);
      check(dir_n == 1'b0, "R11 dir low when idle", int'(dir_n), 0);
      put_byte(8'h5A, 1'b1);
      check(dir_n == 1'b1, "R10 dir high after write", int'(dir_n), 1);
      check(txd == 1'b1,   "R10 dir rises before start bit", int'(txd), 1);
      while (txd) @(negedge clk);
      n = 0;
      while (dir_n) begin
         @(negedge clk);
         n++;
      end
      check(n == 10 * TPB, "R11 dir fall after stop bit", n, 10 * TPB);
      check(tx_irq == 1'b1, "R9 irq with dir fall", int'(tx_irq), 1);
      wait_frames(5);
      put_byte(8'hC3, 1'b1);
      repeat (6) @(negedge clk);
      check(tx_irq == 1'b0, "R9 irq low while shifting", int'(tx_irq), 0);
      wait_frames(6);
      check(tx_irq == 1'b1, "R9 irq high once idle", int'(tx_irq), 1);

      // R5 halt while idle
      tx_halt = 1'b1;
      put_byte(8'h12, 1'b1);
      put_byte(8'h34, 1'b1);
      put_byte(8'h56, 1'b1);
      lows = 0;
      repeat (60) begin
         @(negedge clk);
         if (!txd) lows++;
      end
      check(lows == 0, "R5 no start while halted", lows, 0);
      check(dir_n == 1'b1, "R10 dir high with queued bytes", int'(dir_n), 1);
      check(frames == 6, "R5 nothing sent while halted", frames, 6);
      // R7 release sends them in order
      tx_halt = 1'b0;
      wait_frames(9);
      check(exp_q.size() == 0, "R7 queue drained in order", exp_q.size(), 0);

      // R6 halt in the middle of a frame
      put_byte(8'h11, 1'b1);
      put_byte(8'h22, 1'b1);
      repeat (8) @(negedge clk);
      tx_halt = 1'b1;
      wait_frames(10);
      lows = 0;
      repeat (80) begin
         @(negedge clk);
         if (!txd) lows++;
      end
      check(lows == 0, "R6 next byte held after halt", lows, 0);
      check(frames == 10, "R6 current frame completed only", frames, 10);
      tx_halt = 1'b0;
      wait_frames(11);

      // R4 overflow
      tx_halt = 1'b1;
      for (int i = 0; i < DEPTH; i++) put_byte(8'h40 + 8'(i), 1'b1);
      check(tx_ovf == 1'b0, "R4 no overflow when exactly full", int'(tx_ovf), 0);
      put_byte(8'hEE, 1'b0);
      put_byte(8'hDD, 1'b0);
      check(tx_ovf == 1'b1, "R4 overflow flag", int'(tx_ovf), 1);
      tx_halt = 1'b0;
      wait_frames(11 + DEPTH);
      repeat (120) @(negedge clk);
      check(frames == 11 + DEPTH, "R4 dropped bytes not sent", frames, 11 + DEPTH);
      check(tx_ovf == 1'b1, "R4 overflow sticky", int'(tx_ovf), 1);

      // R2 bit length follows baud ticks
      dir_auto_en = 1'b0;
      tick_div = 3;
      repeat (4) @(negedge clk);
      put_byte(8'h96, 1'b1);
      put_byte(8'h3C, 1'b1);
      wait_frames(13 + DEPTH);

      check(exp_q.size() == 0, "R3 all expected frames seen", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule